// File: doc/BRIEF.md
# Multiprocessor Interrupt Register Block

This block is the interrupt register file for a system of four processors. It keeps a device-interrupt mask for each processor and samples a shared vector of raw device requests. From these it forms each processor's masked result and raises a device-interrupt line for every processor whose result is nonzero. It also holds one pending inter-processor interrupt (IPI) bit and one pending interval-timer bit per processor, and drives those bits out as interrupt lines.

Software reaches the registers over a simple 64-bit request/response bus. A sideband on this bus carries the ID of the requesting processor. Every request is answered exactly one cycle later, with read data or with an error flag. A packed control word lets one write post IPIs, clear IPIs and clear timer interrupts, with a separate processor field for each action. Dedicated status and request registers give direct access to the pending vectors. Timer ticks arrive as an input vector, one bit per processor.

Top module: `cic_regs`

## Requirements
- R1: The register index is bits [ADDR_W-1:6] of the byte address, so registers lie on a 64-byte stride and address bits 5:0 are ignored. The indices are: 0 control, 1 packed control word, 2–5 address-array, 6–9 mask of CPU0–3, 10–13 result of CPU0–3, 14 raw request, 15 IPI status, 16 timer status, 17 IPI request.
- R2: A request whose size code is not 3 (size codes: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit) gets an error response, read data of zero, and changes no state.
- R3: A read of result register n returns mask n AND the raw request register. The raw register samples `dev_req` on every clock. `dev_irq[n]` is high exactly when that AND is nonzero, and it reflects the values written or sampled at the same clock edge.
- R4: A write to the packed control word posts a pending IPI to every CPU n whose bit 12+n is set.
- R5: In the same write, bit 8+n clears the pending IPI of CPU n and bit 4+n clears its pending timer bit. If one write both posts and clears an IPI for the same CPU, the clear wins.
- R6: A packed-control write with bit 28 set and bits 15:4 clear is accepted and changes nothing. A packed-control write with bit 28 and bits 15:4 all clear is an error and changes nothing.
- R7: A read of the packed control word returns the requester's CPU ID in bits 1:0, the pending timer vector in bits 7:4 and the pending IPI vector in bits 11:8. All other bits read zero.
- R8: The IPI status register reads the pending IPI vector, and a write to it clears the pending bits set in wdata[3:0]. The timer status register does the same for timer bits. A write to the IPI request register posts IPIs for wdata[3:0], and a read of it returns zero.
- R9: The control register and the address-array registers read zero, and writes to the address-array registers are accepted without effect. Writes to the control, result or raw registers are errors. Any access to an index above 17 is an error.
- R10: `tick[n]` sets CPU n's pending timer bit. A tick and a clear of the same bit in the same cycle leave the bit set.
- R11: All interrupt outputs are registers and are zero after reset. `ipi_irq` and `tmr_irq` equal the pending vectors one cycle after the write or tick that changed them.
- R12: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_err` is only ever high together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code, 3 = 64-bit |
| req_addr | input | ADDR_W | Byte offset from block base |
| req_wdata | input | 64 | Write data |
| req_cpu | input | 2 | ID of requesting processor |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 64 | Read data, zero on writes and errors |
| dev_req | input | 64 | Raw device interrupt requests |
| tick | input | N_CPU | Interval-timer ticks, one per CPU |
| dev_irq | output | N_CPU | Device interrupt line per CPU |
| ipi_irq | output | N_CPU | IPI line per CPU |
| tmr_irq | output | N_CPU | Timer interrupt line per CPU |

## Verification
Two kinds of event can land on one pending bit in the same cycle. A timer tick can meet a software clear of that bit, and an IPI post can meet an IPI clear inside one packed-control write. The bench forces both collisions with directed cases and also lets the random phase hit them by chance, since its ticks arrive alongside random clear writes. A bench model computes the outcome: a tick wins over a clear, and an IPI clear wins over a post. The interrupt outputs and the status readback are compared against that model every cycle.

// File: rtl/cic_pkg.sv
// Shared definitions for the interrupt register block: register kinds,
// register index map and packed control word field positions.
// Assumes a fixed four-processor map; indices are relied on by software.
package cic_pkg;
    localparam int unsigned DATA_W   = 64;
    localparam logic [1:0]  SZ_64    = 2'd3;

    // register index map (index = byte offset >> 6)
    localparam int unsigned IX_CTRL   = 0;
    localparam int unsigned IX_MISC   = 1;
    localparam int unsigned IX_AAR    = 2;   // 2..5
    localparam int unsigned IX_MASK   = 6;   // 6..9
    localparam int unsigned IX_RES    = 10;  // 10..13
    localparam int unsigned IX_RAW    = 14;
    localparam int unsigned IX_IPIST  = 15;
    localparam int unsigned IX_TMRST  = 16;
    localparam int unsigned IX_IPIREQ = 17;
    localparam int unsigned N_BANK    = 4;   // entries in each per-CPU group

    // packed control word fields
    localparam int unsigned F_TCLR = 4;
    localparam int unsigned F_ICLR = 8;
    localparam int unsigned F_POST = 12;
    localparam int unsigned F_ACK  = 28;

    typedef enum logic [3:0] {
        K_CTRL, K_MISC, K_AAR, K_MASK, K_RES, K_RAW,
        K_IPIST, K_TMRST, K_IPIREQ, K_BAD
    } reg_kind_e;
endpackage

// File: rtl/cic_decode.sv
// Register index decoder: turns a register index into a register kind and,
// for per-CPU groups, the CPU number. Purely combinational.
// Assumes per-CPU groups hold N_BANK consecutive indices.
module cic_decode
    import cic_pkg::*;
#(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned CPU_W = 2
) (
    input  logic [IDX_W-1:0] idx_i,
    output reg_kind_e        kind_o,
    output logic [CPU_W-1:0] sel_o
);
    logic [IDX_W-1:0] off_mask;
    logic [IDX_W-1:0] off_res;

    assign off_mask = idx_i - IDX_W'(IX_MASK);
    assign off_res  = idx_i - IDX_W'(IX_RES);

    // classify the index into a register kind and group member
    always_comb begin
        kind_o = K_BAD;
        sel_o  = '0;
        if (idx_i == IDX_W'(IX_CTRL)) begin
            kind_o = K_CTRL;
        end else if (idx_i == IDX_W'(IX_MISC)) begin
            kind_o = K_MISC;
        end else if (idx_i >= IDX_W'(IX_AAR) && idx_i < IDX_W'(IX_AAR + N_BANK)) begin
            kind_o = K_AAR;
        end else if (idx_i >= IDX_W'(IX_MASK) && idx_i < IDX_W'(IX_MASK + N_BANK)) begin
            kind_o = K_MASK;
            sel_o  = off_mask[CPU_W-1:0];
        end else if (idx_i >= IDX_W'(IX_RES) && idx_i < IDX_W'(IX_RES + N_BANK)) begin
            kind_o = K_RES;
            sel_o  = off_res[CPU_W-1:0];
        end else if (idx_i == IDX_W'(IX_RAW)) begin
            kind_o = K_RAW;
        end else if (idx_i == IDX_W'(IX_IPIST)) begin
            kind_o = K_IPIST;
        end else if (idx_i == IDX_W'(IX_TMRST)) begin
            kind_o = K_TMRST;
        end else if (idx_i == IDX_W'(IX_IPIREQ)) begin
            kind_o = K_IPIREQ;
        end
    end
endmodule

// File: rtl/cic_mask_bank.sv
// Per-CPU device interrupt masks, the sampled raw request register and the
// registered per-CPU device interrupt lines. The line of CPU n is the OR of
// (mask n AND raw), computed from the values being loaded at the same edge.
// Assumes at most one mask write enable is high per cycle.
module cic_mask_bank #(
    parameter int unsigned N_CPU  = 4,
    parameter int unsigned DATA_W = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_CPU-1:0]               wr_en_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic [DATA_W-1:0]              dev_req_i,
    output logic [N_CPU-1:0][DATA_W-1:0]   mask_o,
    output logic [DATA_W-1:0]              raw_o,
    output logic [N_CPU-1:0]               irq_o
);
    logic [DATA_W-1:0] raw_q;

    // sample the raw request vector every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= dev_req_i;
    end
    assign raw_o = raw_q;

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic [DATA_W-1:0] mask_q;
        logic [DATA_W-1:0] mask_d;
        logic              irq_q;

        assign mask_d = wr_en_i[c] ? wdata_i : mask_q;

        // hold the mask and derive the registered interrupt line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
                irq_q  <= 1'b0;
            end else begin
                mask_q <= mask_d;
                irq_q  <= |(mask_d & dev_req_i);
            end
        end
        assign mask_o[c] = mask_q;
        assign irq_o[c]  = irq_q;

        // R3
        irq_matches_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_q == |(mask_q & raw_q));
        // R3
        mask_takes_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i[c] |=> mask_q == $past(wdata_i));
    end
endmodule

// File: rtl/cic_pend.sv
// Vector of pending interrupt bits with per-bit set and clear requests.
// SET_WINS selects which request prevails when both hit one bit in a cycle.
// Assumes set and clear are already qualified by the caller.
module cic_pend #(
    parameter int unsigned W        = 4,
    parameter bit          SET_WINS = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;
    logic [W-1:0] d;

    if (SET_WINS) begin : g_set_wins
        assign d = (q & ~clr_i) | set_i;
    end else begin : g_clr_wins
        assign d = (q | set_i) & ~clr_i;
    end

    // register the pending bits
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
    assign q_o = q;

    // R5
    clr_only_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr_i & ~set_i) |=> (q & $past(clr_i & ~set_i)) == '0);
    // R4
    set_only_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(set_i & ~clr_i) |=> (q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i));

    if (SET_WINS) begin : g_win_chk
        // R10
        set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            |(set_i & clr_i) |=> (q & $past(set_i)) == $past(set_i));
    end else begin : g_lose_chk
        // R5
        clr_beats_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            |(set_i & clr_i) |=> (q & $past(clr_i)) == '0);
    end
endmodule

// File: rtl/cic_regs.sv
// Top of the interrupt register block: bus decode, access checking, the
// packed control word, read multiplexing and the registered response.
// Assumes one request per cycle; every request is answered the next cycle.
module cic_regs
    import cic_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned N_CPU  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [1:0]              req_size,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [1:0]              req_cpu,
    output logic                    rsp_valid,
    output logic                    rsp_err,
    output logic [DATA_W-1:0]       rsp_rdata,
    input  logic [DATA_W-1:0]       dev_req,
    input  logic [N_CPU-1:0]        tick,
    output logic [N_CPU-1:0]        dev_irq,
    output logic [N_CPU-1:0]        ipi_irq,
    output logic [N_CPU-1:0]        tmr_irq
);
    localparam int unsigned IDX_W = ADDR_W - 6;
    localparam int unsigned CPU_W = $clog2(N_CPU);

    reg_kind_e                  kind;
    logic [CPU_W-1:0]           sel;
    logic [N_CPU-1:0][DATA_W-1:0] mask;
    logic [DATA_W-1:0]          raw;
    logic [N_CPU-1:0]           ipi_q, tmr_q;
    logic [N_CPU-1:0]           f_post, f_iclr, f_tclr, w_low;
    logic                       f_ack, misc_any, size_ok, acc_err, go_wr;
    logic [N_CPU-1:0]           mask_wr, ipi_set, ipi_clr, tmr_clr;
    logic [DATA_W-1:0]          misc_rd, rd_data;
    logic                       rsp_valid_q, rsp_err_q;
    logic [DATA_W-1:0]          rdata_q;
    logic                       unused_addr;

    assign unused_addr = ^req_addr[5:0];

    cic_decode #(.IDX_W(IDX_W), .CPU_W(CPU_W)) u_dec (
        .idx_i  (req_addr[ADDR_W-1:6]),
        .kind_o (kind),
        .sel_o  (sel)
    );

    // split the packed control word into its fields
    always_comb begin
        f_post   = req_wdata[F_POST +: N_CPU];
        f_iclr   = req_wdata[F_ICLR +: N_CPU];
        f_tclr   = req_wdata[F_TCLR +: N_CPU];
        f_ack    = req_wdata[F_ACK];
        w_low    = req_wdata[N_CPU-1:0];
        misc_any = (|f_post) | (|f_iclr) | (|f_tclr) | f_ack;
    end

    // decide whether the access is refused
    always_comb begin
        size_ok = (req_size == SZ_64);
        if (!size_ok) begin
            acc_err = 1'b1;
        end else if (req_write) begin
            acc_err = (kind == K_CTRL) || (kind == K_RES) || (kind == K_RAW) ||
                      (kind == K_BAD)  || ((kind == K_MISC) && !misc_any);
        end else begin
            acc_err = (kind == K_BAD);
        end
        go_wr = req_valid && req_write && !acc_err;
    end

    // route accepted writes to mask, IPI and timer update requests
    always_comb begin
        mask_wr = '0;
        ipi_set = '0;
        ipi_clr = '0;
        tmr_clr = '0;
        if (go_wr) begin
            case (kind)
                K_MASK:   mask_wr[sel] = 1'b1;
                K_MISC:   begin
                    ipi_set = f_post;
                    ipi_clr = f_iclr;
                    tmr_clr = f_tclr;
                end
                K_IPIREQ: ipi_set = w_low;
                K_IPIST:  ipi_clr = w_low;
                K_TMRST:  tmr_clr = w_low;
                default:  ;
            endcase
        end
    end

    cic_mask_bank #(.N_CPU(N_CPU), .DATA_W(DATA_W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (mask_wr),
        .wdata_i   (req_wdata),
        .dev_req_i (dev_req),
        .mask_o    (mask),
        .raw_o     (raw),
        .irq_o     (dev_irq)
    );

    cic_pend #(.W(N_CPU), .SET_WINS(1'b0)) u_ipi (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ipi_set),
        .clr_i (ipi_clr),
        .q_o   (ipi_q)
    );

    cic_pend #(.W(N_CPU), .SET_WINS(1'b1)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (tick),
        .clr_i (tmr_clr),
        .q_o   (tmr_q)
    );

    assign ipi_irq = ipi_q;
    assign tmr_irq = tmr_q;

    // assemble the packed control word readback
    always_comb begin
        misc_rd                 = '0;
        misc_rd[CPU_W-1:0]      = req_cpu[CPU_W-1:0];
        misc_rd[F_TCLR +: N_CPU] = tmr_q;
        misc_rd[F_ICLR +: N_CPU] = ipi_q;
    end

    // select read data by register kind
    always_comb begin
        case (kind)
            K_MISC:  rd_data = misc_rd;
            K_MASK:  rd_data = mask[sel];
            K_RES:   rd_data = mask[sel] & raw;
            K_RAW:   rd_data = raw;
            K_IPIST: rd_data = DATA_W'(ipi_q);
            K_TMRST: rd_data = DATA_W'(tmr_q);
            default: rd_data = '0;
        endcase
    end

    // register the bus response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rdata_q     <= '0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_err_q   <= req_valid && acc_err;
            rdata_q     <= (req_valid && !req_write && !acc_err) ? rd_data : '0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_err   = rsp_err_q;
    assign rsp_rdata = rdata_q;

    // R12
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R12
    no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R12
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
    // R2
    narrow_access_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != SZ_64) |=> (rsp_err && rsp_rdata == '0));
    // R9
    ctrl_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && kind == K_CTRL) |=> rsp_err);
    // R2
    narrow_keeps_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != SZ_64) |=> ipi_q == $past(ipi_q));
endmodule

// File: tb/cic_regs_tb.sv
module cic_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd3;
    logic [10:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_cpu = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic [63:0] dev_req = '0;
    logic [3:0]  tick = '0;
    logic [3:0]  dev_irq, ipi_irq, tmr_irq;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [63:0] m_mask [4];
    logic [63:0] m_raw;
    logic [3:0]  m_ipi, m_tmr;

    always #(CLK_PERIOD/2) clk = ~clk;

    cic_regs u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .dev_req(dev_req), .tick(tick),
        .dev_irq(dev_irq), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_err(input bit wr, input logic [1:0] sz, input int idx,
                                   input logic [63:0] d);
        if (sz != 2'd3) return 1'b1;
        if (idx > 17) return 1'b1;
        if (!wr) return 1'b0;
        if (idx == 0 || (idx >= 10 && idx <= 14)) return 1'b1;
        if (idx == 1 && d[15:4] == 12'h0 && !d[28]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [63:0] exp_read(input int idx, input logic [1:0] cpu);
        if (idx == 1) return {52'h0, m_ipi, m_tmr, 2'b00, cpu};
        if (idx >= 6 && idx <= 9) return m_mask[idx-6];
        if (idx >= 10 && idx <= 13) return m_mask[idx-10] & m_raw;
        if (idx == 14) return m_raw;
        if (idx == 15) return {60'h0, m_ipi};
        if (idx == 16) return {60'h0, m_tmr};
        return 64'h0;
    endfunction

    function automatic logic [3:0] exp_dev();
        logic [3:0] v;
        for (int c = 0; c < 4; c++) v[c] = |(m_mask[c] & m_raw);
        return v;
    endfunction

    // one bus cycle: drive, update model, check response and outputs
    task automatic op(input string tag, input bit vld, input bit wr, input logic [1:0] sz,
                      input int idx, input logic [5:0] low, input logic [63:0] d,
                      input logic [1:0] cpu, input logic [3:0] tk, input logic [63:0] dv);
        bit e;
        logic [63:0] rd;
        logic [3:0] tclr;
        @(negedge clk);
        req_valid = vld; req_write = wr; req_size = sz;
        req_addr = {idx[4:0], low}; req_wdata = d; req_cpu = cpu;
        tick = tk; dev_req = dv;
        e  = exp_err(wr, sz, idx, d);
        rd = (vld && !wr && !e) ? exp_read(idx, cpu) : 64'h0;
        tclr = 4'h0;
        if (vld && wr && !e) begin
            if (idx >= 6 && idx <= 9) m_mask[idx-6] = d;
            if (idx == 1) begin
                m_ipi = (m_ipi | d[15:12]) & ~d[11:8];
                tclr  = d[7:4];
            end
            if (idx == 15) m_ipi = m_ipi & ~d[3:0];
            if (idx == 16) tclr  = d[3:0];
            if (idx == 17) m_ipi = m_ipi | d[3:0];
        end
        m_tmr = (m_tmr & ~tclr) | tk;
        m_raw = dv;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        tick = 4'h0;
        check({tag, " R12 rsp_valid"}, 64'(rsp_valid), 64'(vld));
        check({tag, " R2/R9 rsp_err"}, 64'(rsp_err), 64'(vld && e));
        check({tag, " rdata"}, rsp_rdata, rd);
        check({tag, " R3 dev_irq"}, 64'(dev_irq), 64'(exp_dev()));
        check({tag, " R11 ipi_irq"}, 64'(ipi_irq), 64'(m_ipi));
        check({tag, " R11 tmr_irq"}, 64'(tmr_irq), 64'(m_tmr));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] cur_dv;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) m_mask[c] = '0;
        m_raw = '0; m_ipi = '0; m_tmr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R11 R12 reset state
        check("R11 reset dev_irq", 64'(dev_irq), 64'h0);
        check("R11 reset ipi_irq", 64'(ipi_irq), 64'h0);
        check("R11 reset tmr_irq", 64'(tmr_irq), 64'h0);
        check("R12 reset rsp_valid", 64'(rsp_valid), 64'h0);

        // R1 mask write and readback through an unaligned offset
        op("R1 mask2 wr", 1, 1, 2'd3, 8, 6'h00, 64'h00F0_0000_0000_0011, 0, 0, 64'h0);
        op("R1 mask2 rd+0x38", 1, 0, 2'd3, 8, 6'h38, 0, 0, 0, 64'h0);
        // R3 device request pattern and result readback
        op("R3 raw on", 1, 0, 2'd3, 12, 6'h00, 0, 0, 0, 64'h0000_0000_0000_0010);
        op("R3 res2 rd", 1, 0, 2'd3, 12, 6'h08, 0, 0, 0, 64'h0000_0000_0000_0010);
        op("R3 raw off", 0, 0, 2'd3, 0, 0, 0, 0, 0, 64'h0100_0000_0000_0000);
        // R4 post IPIs to CPU1 and CPU3
        op("R4 misc post", 1, 1, 2'd3, 1, 0, 64'h0000_A000, 0, 0, 64'h0);
        // R5 post and clear CPU0 together -> clear wins; clear CPU1
        op("R5 post+clr", 1, 1, 2'd3, 1, 0, 64'h0000_1300, 0, 0, 64'h0);
        // R6 error-acknowledge alone, then empty word
        op("R6 ack only", 1, 1, 2'd3, 1, 0, 64'h1000_0000, 0, 0, 64'h0);
        op("R6 empty misc", 1, 1, 2'd3, 1, 0, 64'h0, 0, 0, 64'h0);
        // R10 tick CPU2, then tick and clear CPU2 in one cycle
        op("R10 tick", 0, 0, 2'd3, 0, 0, 0, 0, 4'b0100, 64'h0);
        op("R10 tick+clr", 1, 1, 2'd3, 1, 0, 64'h0000_0040, 0, 4'b0100, 64'h0);
        // R7 packed readback for CPU3
        op("R7 misc rd", 1, 0, 2'd3, 1, 0, 0, 2'd3, 0, 64'h0);
        // R8 status and request registers
        op("R8 ipireq wr", 1, 1, 2'd3, 17, 0, 64'h5, 0, 0, 64'h0);
        op("R8 ipireq rd", 1, 0, 2'd3, 17, 0, 0, 0, 0, 64'h0);
        op("R8 ipist rd", 1, 0, 2'd3, 15, 0, 0, 0, 0, 64'h0);
        op("R8 ipist clr", 1, 1, 2'd3, 15, 0, 64'h9, 0, 0, 64'h0);
        op("R8 tmrst clr", 1, 1, 2'd3, 16, 0, 64'h4, 0, 0, 64'h0);
        op("R8 tmrst rd", 1, 0, 2'd3, 16, 0, 0, 0, 0, 64'h0);
        // R9 control, address-array, unlisted index
        op("R9 ctrl rd", 1, 0, 2'd3, 0, 0, 0, 0, 0, 64'h0);
        op("R9 ctrl wr", 1, 1, 2'd3, 0, 0, 64'hFFFF, 0, 0, 64'h0);
        op("R9 aar wr", 1, 1, 2'd3, 3, 0, 64'hFFFF, 0, 0, 64'h0);
        op("R9 aar rd", 1, 0, 2'd3, 3, 0, 0, 0, 0, 64'h0);
        op("R9 res wr", 1, 1, 2'd3, 11, 0, 64'h1, 0, 0, 64'h0);
        op("R9 bad idx", 1, 0, 2'd3, 20, 0, 0, 0, 0, 64'h0);
        // R2 narrow write to a mask is refused and leaves it alone
        op("R2 narrow wr", 1, 1, 2'd2, 8, 0, 64'h0, 0, 0, 64'h0);
        op("R2 mask kept", 1, 0, 2'd3, 8, 0, 0, 0, 0, 64'h0);
        op("R2 narrow misc", 1, 1, 2'd0, 1, 0, 64'hF000, 0, 0, 64'h0);

        // random phase
        cur_dv = 64'h0;
        for (int i = 0; i < N_RAND; i++) begin
            int          sel;
            int          idx;
            logic [63:0] d;
            logic [1:0]  sz;
            logic [3:0]  tk;
            sel = int'($urandom % 10);
            d   = {$urandom, $urandom};
            sz  = ($urandom % 8 == 0) ? 2'($urandom) : 2'd3;
            tk  = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
            if ($urandom % 5 == 0) cur_dv = 64'(1) << ($urandom % 64);
            case (sel)
                0, 1: idx = 6 + int'($urandom % 4);
                2, 3: idx = 1;
                4:    idx = 15 + int'($urandom % 3);
                default: idx = int'($urandom % 20);
            endcase
            if (idx == 1) d = d & 64'h1000_FFF0;
            if (idx >= 6 && idx <= 9 && $urandom % 2 == 0) d = d & 64'h0000_0000_FFFF_0000;
            op("RND R4/R5/R10", ($urandom % 8 != 0), ($urandom % 2 == 0), sz, idx,
               6'($urandom), d, 2'($urandom), tk, cur_dv);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule